// File: doc/BRIEF.md
# Four-Way Set-Associative Word Cache

This block sits between a processor's load/store port and a slower word-wide memory. Every entry holds one 32-bit word. The address picks one set. All four ways of that set are compared at the same time. A hit returns its word in the same cycle as the request. A miss stalls the processor. The block then asks memory for the word and writes it into a way of the set. The access is then presented again and completes as a hit.

Each set keeps a full recency order of its four ways. An empty way is always used first. When the set is full, the way used longest ago is replaced. Writes go into the cache and out to memory at the same time (write-through). A write miss first brings the word in, then writes it. The number of sets is a parameter.

The processor must hold its request steady while stall is high.

Top module: `sa4_cache`

## Requirements
- R1: The address fields are tag = bits 31:10, set index = bits 9:2 (256 sets by default), and byte offset = bits 1:0. The offset has no effect on hit, data or the memory address. `mem_addr` is the request address with bits 1:0 forced to zero.
- R2: A request whose tag matches a valid way in its set raises `hit` in the same cycle, with `stall` low. `rdata` carries that way's word.
- R3: At most one way of a set matches any tag.
- R4: A miss raises `stall` in the same cycle and pulses `mem_req` for one cycle. `stall` stays high until the cycle after `mem_rvalid`. In that cycle the request completes as a hit returning `mem_rdata`.
- R5: While a set has an invalid way, a refill uses an invalid way, so no valid word of that set is lost.
- R6: When all four ways of a set are valid, a refill replaces the least recently used way.
- R7: Every hit and every refill makes the touched way the most recent in its set. A way that was just touched therefore survives the next eviction.
- R8: A write hit stores `req_wdata` in the hitting way. In that same cycle it raises `mem_wen` with `mem_addr` and `mem_wdata` carrying the aligned address and the data. Reads return the new word. `mem_wen` is low on every other cycle.
- R9: A write miss first refills the word from memory and then completes as a write hit.
- R10: After reset every way is invalid, the order of each set is way 0 oldest through way 3 newest, and with no request `hit`, `stall`, `mem_req` and `mem_wen` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor access request, held while stall is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| hit | output | 1 | Access completes this cycle |
| rdata | output | 32 | Read data, valid with hit |
| stall | output | 1 | Processor must hold and wait |
| mem_req | output | 1 | One-cycle refill request |
| mem_wen | output | 1 | Write-through strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-through data |
| mem_rvalid | input | 1 | Refill word is present |
| mem_rdata | input | 32 | Refill word |

## Verification
The hardest state to reach from the ports is a full set whose recency order no longer matches its fill order. Only then does a wrong choice of victim show up as a wrong hit or miss later on. The bench gets there by filling one set with four tags and touching selected tags again. It then brings in a fifth tag and probes which older tags survived. A long mixed stream of reads and writes follows, confined to two sets with six competing tags each. Every hit, miss and returned word is compared against a timestamp-based model of the cache and a model of memory.

// File: rtl/sa4_pkg.sv
package sa4_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int RANK_W = WAY_W;

    typedef enum logic [0:0] {
        ST_LOOK = 1'b0,
        ST_FILL = 1'b1
    } st_e;

    typedef struct packed {
        st_e              st;
        logic [WAY_W-1:0] victim;
    } ctl_t;
endpackage

// File: rtl/sa4_match.sv
module sa4_match
    import sa4_pkg::*;
#(
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][DATA_W-1:0] way_data,
    input  logic [TAG_W-1:0]            look_tag,
    output logic [WAYS-1:0]             way_hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        any_hit,
    output logic [DATA_W-1:0]           hit_data
);
    // one comparator per way, all working in parallel
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_hit[g] = way_valid[g] && (way_tag[g] == look_tag);
    end

    assign any_hit = |way_hit;

    // one-hot steered data select and way encoder
    always_comb begin
        hit_data = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                hit_data = hit_data | way_data[w];
                hit_way  = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/sa4_lru.sv
module sa4_lru
    import sa4_pkg::*;
(
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][RANK_W-1:0] rank_cur,
    input  logic [WAY_W-1:0]            touch_way,
    output logic [WAY_W-1:0]            victim_way,
    output logic [WAYS-1:0][RANK_W-1:0] rank_next
);
    logic found;

    // empty ways first (lowest number), else the rank-0 way
    always_comb begin
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (rank_cur[w] == '0) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

    // touched way becomes newest; newer ways shift down by one
    always_comb begin
        for (int j = 0; j < WAYS; j++) begin
            if (WAY_W'(j) == touch_way) begin
                rank_next[j] = RANK_W'(WAYS - 1);
            end else if (rank_cur[j] > rank_cur[touch_way]) begin
                rank_next[j] = rank_cur[j] - 1'b1;
            end else begin
                rank_next[j] = rank_cur[j];
            end
        end
    end
endmodule

// File: rtl/sa4_cache.sv
module sa4_cache
    import sa4_pkg::*;
#(
    parameter int SETS   = 256,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              stall,
    output logic              mem_req,
    output logic              mem_wen,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W   = 2;
    localparam int INDEX_W = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;

    // storage
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0][RANK_W-1:0] rank_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

    ctl_t ctl_d, ctl_q;

    logic [INDEX_W-1:0]          idx;
    logic [TAG_W-1:0]            look_tag;
    logic [WAYS-1:0]             way_hit;
    logic [WAY_W-1:0]            hit_way;
    logic                        look_hit;
    logic [WAY_W-1:0]            victim_way;
    logic [WAY_W-1:0]            touch_way;
    logic [WAYS-1:0][RANK_W-1:0] cur_rank;
    logic [WAYS-1:0][RANK_W-1:0] rank_next;
    logic                        lru_en;
    logic                        fill_en;
    logic                        wr_en;
    logic                        unused_off;

    assign idx        = req_addr[OFF_W +: INDEX_W];
    assign look_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign cur_rank   = rank_q[idx];
    assign unused_off = ^req_addr[OFF_W-1:0];

    sa4_match #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_match (
        .way_valid (valid_q[idx]),
        .way_tag   (tag_q[idx]),
        .way_data  (data_q[idx]),
        .look_tag  (look_tag),
        .way_hit   (way_hit),
        .hit_way   (hit_way),
        .any_hit   (look_hit),
        .hit_data  (rdata)
    );

    assign touch_way = (ctl_q.st == ST_FILL) ? ctl_q.victim : hit_way;

    sa4_lru u_lru (
        .way_valid  (valid_q[idx]),
        .rank_cur   (cur_rank),
        .touch_way  (touch_way),
        .victim_way (victim_way),
        .rank_next  (rank_next)
    );

    assign mem_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = req_wdata;

    // next-state logic
    always_comb begin
        ctl_d   = ctl_q;
        hit     = 1'b0;
        stall   = 1'b0;
        mem_req = 1'b0;
        mem_wen = 1'b0;
        lru_en  = 1'b0;
        fill_en = 1'b0;
        wr_en   = 1'b0;
        case (ctl_q.st)
            ST_LOOK: begin
                if (req_valid) begin
                    if (look_hit) begin
                        hit     = 1'b1;
                        lru_en  = 1'b1;
                        wr_en   = req_write;
                        mem_wen = req_write;
                    end else begin
                        stall        = 1'b1;
                        mem_req      = 1'b1;
                        ctl_d.victim = victim_way;
                        ctl_d.st     = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                stall = 1'b1;
                if (mem_rvalid) begin
                    fill_en  = 1'b1;
                    lru_en   = 1'b1;
                    ctl_d.st = ST_LOOK;
                end
            end
            default: ctl_d.st = ST_LOOK;
        endcase
    end

    // control, valid bits and recency ranks (reset)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_LOOK, victim: '0};
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= RANK_W'(w);
                end
            end
        end else begin
            ctl_q <= ctl_d;
            if (lru_en) begin
                rank_q[idx] <= rank_next;
            end
            if (fill_en) begin
                valid_q[idx][ctl_q.victim] <= 1'b1;
            end
        end
    end

    // tags and data words (no reset)
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx][ctl_q.victim]  <= look_tag;
            data_q[idx][ctl_q.victim] <= mem_rdata;
        end else if (wr_en) begin
            data_q[idx][hit_way] <= req_wdata;
        end
    end
endmodule

// File: rtl/sa4_cache_chk.sv
module sa4_cache_chk
    import sa4_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic                        hit,
    input logic                        stall,
    input logic                        mem_req,
    input logic                        mem_wen,
    input logic [WAYS-1:0]             way_hit,
    input logic [WAYS-1:0][RANK_W-1:0] cur_rank
);
    logic [WAYS-1:0] rank_seen;

    always_comb begin
        rank_seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            rank_seen[cur_rank[w]] = 1'b1;
        end
    end

    a_r3_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !stall);

    a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |-> stall);

    a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (stall && !mem_req));

    a_r8_wen_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wen |-> (hit && req_write));

    a_r7_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
        rank_seen == {WAYS{1'b1}});
endmodule

bind sa4_cache sa4_cache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .hit       (hit),
    .stall     (stall),
    .mem_req   (mem_req),
    .mem_wen   (mem_wen),
    .way_hit   (way_hit),
    .cur_rank  (cur_rank)
);

// File: tb/sa4_cache_test.sv
module sa4_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int NSETS      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        hit, stall, mem_req, mem_wen;
    logic [31:0] rdata, mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    sa4_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .hit(hit), .rdata(rdata),
        .stall(stall), .mem_req(mem_req), .mem_wen(mem_wen), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference models: memory contents and a timestamp cache
    logic [31:0] mem_model [logic [31:0]];
    bit          mv    [NSETS][4];
    logic [21:0] mt    [NSETS][4];
    int          mtime [NSETS][4];
    int          stamp = 0;

    function automatic logic [31:0] mk(input logic [21:0] t, input logic [7:0] i,
                                       input logic [1:0] o);
        return {t, i, o};
    endfunction

    function automatic logic [31:0] mem_peek(input logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        if (mem_model.exists(k)) return mem_model[k];
        return k ^ 32'h5A3C_96E1;
    endfunction

    function automatic bit model_access(input logic [31:0] a);
        int s = int'(a[9:2]);
        int v = -1;
        stamp++;
        for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == a[31:10]) v = w;
        if (v >= 0) begin
            mtime[s][v] = stamp;
            return 1'b0;
        end
        for (int w = 0; w < 4; w++) if (!mv[s][w] && v < 0) v = w;
        if (v < 0) begin
            v = 0;
            for (int w = 1; w < 4; w++) if (mtime[s][w] < mtime[s][v]) v = w;
        end
        mv[s][v] = 1'b1; mt[s][v] = a[31:10]; mtime[s][v] = stamp;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input string req);
        int          miss = 0;
        int          guard = 0;
        bit          done = 0;
        bit          exp_miss;
        logic [31:0] got = '0;
        logic [31:0] exp_data = mem_peek(a);
        exp_miss = model_access(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        while (!done && guard < 50) begin
            guard++;
            if (hit) begin
                got = rdata;
                chk(!stall, req, "stall with hit", 32'(stall), 0);
                if (wr) begin
                    chk(mem_wen, "R8", "write-through strobe", 32'(mem_wen), 1);
                    chk(mem_addr == {a[31:2], 2'b00}, "R8", "write-through addr", mem_addr,
                        {a[31:2], 2'b00});
                    chk(mem_wdata == wd, "R8", "write-through data", mem_wdata, wd);
                end else begin
                    chk(!mem_wen, "R8", "no strobe on read", 32'(mem_wen), 0);
                end
                done = 1;
            end else begin
                chk(stall, "R4", "stall on miss", 32'(stall), 1);
                if (mem_req) begin
                    miss++;
                    chk(mem_addr == {a[31:2], 2'b00}, "R1", "refill addr aligned", mem_addr,
                        {a[31:2], 2'b00});
                    for (int c = 0; c < MEM_LAT; c++) begin
                        @(negedge clk); #1;
                        chk(stall && !mem_req && !hit, "R4", "waiting for memory",
                            {29'd0, stall, mem_req, hit}, 32'b100);
                    end
                    mem_rvalid = 1'b1; mem_rdata = mem_peek(a);
                    @(negedge clk);
                    mem_rvalid = 1'b0; mem_rdata = '0;
                    #1;
                end else begin
                    @(negedge clk); #1;
                end
            end
        end
        chk(done, req, "access completed", 32'(done), 1);
        chk(miss == int'(exp_miss), req, "miss count", miss, 32'(exp_miss));
        if (!wr) chk(got == exp_data, req, "read data", got, exp_data);
        else mem_model[{a[31:2], 2'b00}] = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!hit && !stall && !mem_req && !mem_wen, "R10", "idle outputs after reset",
            {28'd0, hit, stall, mem_req, mem_wen}, 0);
        access(0, mk(22'h0ABCD, 8'd1, 2'd0), 0, "R10");
    endtask

    task automatic t_basic();
        access(0, mk(22'h01234, 8'd2, 2'd0), 0, "R4");
        access(0, mk(22'h01234, 8'd2, 2'd0), 0, "R2");
        access(0, mk(22'h01234, 8'd2, 2'd3), 0, "R1");
        access(0, mk(22'h01234, 8'd3, 2'd1), 0, "R1");
    endtask

    task automatic t_fill_set();
        for (int t = 0; t < 4; t++) access(0, mk(22'(16 + t), 8'd20, 2'd0), 0, "R5");
        for (int t = 0; t < 4; t++) access(0, mk(22'(16 + t), 8'd20, 2'd0), 0, "R5");
    endtask

    task automatic t_lru_evict();
        access(0, mk(22'd20, 8'd20, 2'd0), 0, "R6");
        access(0, mk(22'd16, 8'd20, 2'd0), 0, "R6");
        access(0, mk(22'd19, 8'd20, 2'd0), 0, "R6");
    endtask

    task automatic t_touch();
        for (int t = 0; t < 4; t++) access(0, mk(22'(40 + t), 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd40, 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd41, 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd44, 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd40, 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd41, 8'd40, 2'd0), 0, "R7");
        access(0, mk(22'd42, 8'd40, 2'd0), 0, "R7");
    endtask

    task automatic t_write_hit();
        access(0, mk(22'h3000, 8'd60, 2'd0), 0, "R8");
        access(1, mk(22'h3000, 8'd60, 2'd2), 32'hCAFE_0001, "R8");
        access(0, mk(22'h3000, 8'd60, 2'd0), 0, "R8");
    endtask

    task automatic t_write_miss();
        access(1, mk(22'h3100, 8'd61, 2'd0), 32'hBEEF_0002, "R9");
        access(0, mk(22'h3100, 8'd61, 2'd0), 0, "R9");
    endtask

    task automatic t_mixed();
        logic [15:0] lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            logic [7:0]  s;
            logic [21:0] t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = lfsr[0] ? 8'd90 : 8'd91;
            t = 22'(100 + (lfsr[7:1] % 6));
            access(lfsr[9] & lfsr[11], mk(t, s, lfsr[15:14]), {lfsr, lfsr ^ 16'h1357},
                   "R3");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_fill_set();
        t_lru_evict();
        t_touch();
        t_write_hit();
        t_write_miss();
        t_mixed();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule